// File: doc/BRIEF.md
# Download Command Parser with Block Checksum

This block sits between a byte receiver and a flash sequencer. It hunts for a fixed four-character ASCII header in the incoming byte stream. It reads an operation byte, a start offset and a block count, and checks the offset and count against the flash geometry. For each block it then streams the received data words out to the sequencer while it keeps a running additive checksum. When the trailing checksum word matches, it issues one program or verify command for that block.

The sequencer answers each command with a done strobe and a result code. Any failure, whether from parsing or from the sequencer, parks the block in an error state with a status code. It leaves that state only after a debounced press of the front-panel button, and then returns to header hunting. Flash command sequencing and any display of the status are outside the block.

Top module: `dl_cmd_parser`

## Requirements
- R1: After reset `status_o` is 0 (waiting), `byte_ready_o` is 1, and `cmd_valid_o` and `word_valid_o` are 0.
- R2: The header is the byte sequence 0x4D 0x50 0x54 0x21 ("MPT!"). A byte that breaks the sequence is consumed and restarts the search at the first header byte. This raises no error, and `status_o` stays 0.
- R3: The byte after the header selects the mode. 0x50 ('P') gives program mode with status 1, 0x56 ('V') gives verify mode with status 2, and any other value returns to the header search with status 0.
- R4: A 32-bit byte offset follows, least significant byte first. An offset at or beyond the flash size, or one with any bit set below the block size, gives status 6 (offset error) as soon as its last byte arrives.
- R5: One count byte follows. A count of zero, or an offset plus count times the block size above the flash size, gives status 7 (count error). Otherwise the status becomes 3 (reading).
- R6: While reading, each group of four data bytes forms one word, least significant byte first. The word appears on `word_o` with `word_valid_o` high, combinationally, in the cycle its fourth byte is accepted. No other phase raises `word_valid_o`.
- R7: After 2^BLK_WORDS_LOG2 data words, a checksum word follows. If it equals the modulo-2^32 sum of the block's words, then `cmd_valid_o` pulses high for exactly one cycle, starting the cycle after the last checksum byte. During that pulse `cmd_prog_o` gives the mode and `cmd_addr_o` gives the block's byte address. On a mismatch, status 8 (checksum error) is set and no command is issued.
- R8: While a command is outstanding, `byte_ready_o` is 0. The status is 4 (writing) in program mode and switches to 5 (verifying) once `seq_vphase_i` is high. In verify mode the status is 5.
- R9: A `seq_done_i` with a nonzero `seq_err_i` sets an error status. Code 1 (erase) gives 9, 2 (voltage) gives 10, 3 (protect) gives 11, 4 (program) gives 12, and 5 or more (verify mismatch) gives 13.
- R10: A `seq_done_i` with `seq_err_i` of 0 advances the block address by the block size and returns to reading (status 3). After the last counted block it returns to waiting (status 0).
- R11: In any error state, `byte_ready_o` is 0 and the status holds. The block restarts at waiting only after `btn_i` has been high for DEB_CYCLES consecutive cycles after synchronisation. A shorter pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_valid_i | input | 1 | Incoming byte is valid |
| byte_i | input | 8 | Incoming byte |
| byte_ready_o | output | 1 | Parser accepts a byte this cycle |
| btn_i | input | 1 | Raw front-panel button, active high |
| seq_vphase_i | input | 1 | Sequencer has reached its verify phase |
| seq_done_i | input | 1 | Sequencer finished the current command |
| seq_err_i | input | 3 | Sequencer result code, valid with done |
| word_valid_o | output | 1 | Data word strobe |
| word_o | output | 32 | Assembled data word |
| cmd_valid_o | output | 1 | Per-block command strobe |
| cmd_prog_o | output | 1 | 1 = program, 0 = verify |
| cmd_addr_o | output | 32 | Block byte address |
| status_o | output | 4 | Encoded status |

## Verification
The bench builds the block with 8-word blocks (32 bytes), an 8-block flash of 256 bytes and a 4-cycle debounce. These values put every flash-size edge within reach in a few hundred cycles: the last legal block, one block past the end, an unaligned offset, a count that runs past the end, and a count of 255. With short blocks, one run can also hold multi-block transfers, every sequencer error code, and short and long button presses. Data words are drawn from a seeded random source and checked against sums computed in the bench.

// File: rtl/dl_pkg.sv
package dl_pkg;
  typedef enum logic [3:0] {
    ST_WAIT      = 4'd0,
    ST_BEGIN_PRG = 4'd1,
    ST_BEGIN_VFY = 4'd2,
    ST_READ      = 4'd3,
    ST_WRITE     = 4'd4,
    ST_VERIFY    = 4'd5,
    ST_E_OFFSET  = 4'd6,
    ST_E_COUNT   = 4'd7,
    ST_E_CSUM    = 4'd8,
    ST_E_ERASE   = 4'd9,
    ST_E_VOLT    = 4'd10,
    ST_E_PROT    = 4'd11,
    ST_E_PROG    = 4'd12,
    ST_E_VMIS    = 4'd13
  } status_e;

  typedef enum logic [2:0] {
    P_HDR, P_OP, P_OFF, P_CNT, P_DATA, P_CSUM, P_SEQ, P_ERR
  } phase_e;

  localparam logic [7:0] CH_M = 8'h4D;
  localparam logic [7:0] CH_P = 8'h50;
  localparam logic [7:0] CH_T = 8'h54;
  localparam logic [7:0] CH_X = 8'h21;
  localparam logic [7:0] CH_V = 8'h56;
endpackage

// File: rtl/dl_debounce.sv
module dl_debounce #(
  parameter int DEB_CYCLES = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic press_o
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  logic s1_q, s2_q, stable_q, press_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0; s2_q <= 1'b0; stable_q <= 1'b0;
      cnt_q <= '0; press_q <= 1'b0;
    end else begin
      s1_q    <= btn_i;
      s2_q    <= s1_q;
      press_q <= 1'b0;
      if (s2_q == stable_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(DEB_CYCLES - 1)) begin
        cnt_q    <= '0;
        stable_q <= s2_q;
        press_q  <= s2_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign press_o = press_q;

  a_r11_press_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_o |=> !press_o);
endmodule

// File: rtl/dl_word_asm.sv
module dl_word_asm (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        take_i,
  input  logic [7:0]  byte_i,
  output logic        done_o,
  output logic [31:0] word_o
);
  logic [1:0]  idx_q;
  logic [23:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      acc_q <= '0;
    end else if (clr_i) begin
      idx_q <= '0;
    end else if (take_i) begin
      idx_q <= idx_q + 1'b1;
      case (idx_q)
        2'd0:    acc_q[7:0]   <= byte_i;
        2'd1:    acc_q[15:8]  <= byte_i;
        2'd2:    acc_q[23:16] <= byte_i;
        default: ;
      endcase
    end
  end

  assign done_o = take_i && !clr_i && (idx_q == 2'd3);
  assign word_o = {byte_i, acc_q};
endmodule

// File: rtl/dl_range_chk.sv
module dl_range_chk #(
  parameter int BLK_BYTES_LOG2 = 18,
  parameter int FLASH_BLOCKS   = 64
) (
  input  logic [31:0] offset_i,
  input  logic [7:0]  count_i,
  output logic        off_bad_o,
  output logic        cnt_bad_o
);
  localparam int SUM_W = ((32 > 8 + BLK_BYTES_LOG2) ? 32 : 8 + BLK_BYTES_LOG2) + 1;
  localparam logic [SUM_W-1:0] FLASH_BYTES = SUM_W'(FLASH_BLOCKS) << BLK_BYTES_LOG2;

  logic [SUM_W-1:0] off_w, end_w;

  always_comb begin
    off_w     = SUM_W'(offset_i);
    end_w     = off_w + (SUM_W'(count_i) << BLK_BYTES_LOG2);
    off_bad_o = (off_w >= FLASH_BYTES) || (offset_i[BLK_BYTES_LOG2-1:0] != '0);
    cnt_bad_o = (count_i == 8'd0) || (end_w > FLASH_BYTES);
  end
endmodule

// File: rtl/dl_cmd_parser.sv
module dl_cmd_parser
  import dl_pkg::*;
#(
  parameter int BLK_WORDS_LOG2 = 16,
  parameter int FLASH_BLOCKS   = 64,
  parameter int DEB_CYCLES     = 500000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        byte_valid_i,
  input  logic [7:0]  byte_i,
  output logic        byte_ready_o,
  input  logic        btn_i,
  input  logic        seq_vphase_i,
  input  logic        seq_done_i,
  input  logic [2:0]  seq_err_i,
  output logic        word_valid_o,
  output logic [31:0] word_o,
  output logic        cmd_valid_o,
  output logic        cmd_prog_o,
  output logic [31:0] cmd_addr_o,
  output logic [3:0]  status_o
);
  localparam int BLK_BYTES_LOG2 = BLK_WORDS_LOG2 + 2;
  localparam logic [31:0] BLK_BYTES = 32'(1) << BLK_BYTES_LOG2;
  localparam logic [31:0] FLASH_LIM = 32'(FLASH_BLOCKS) << BLK_BYTES_LOG2;

  phase_e  ph_q;
  status_e st_q;
  logic [1:0]  hdr_idx_q;
  logic        prog_q, cmd_q;
  logic [31:0] off_q, addr_q, csum_q;
  logic [7:0]  left_q;
  logic [BLK_WORDS_LOG2-1:0] widx_q;

  logic take, asm_take, asm_done, press, off_bad, cnt_bad;
  logic [31:0] asm_word;

  function automatic logic [7:0] hdr_char(input logic [1:0] i);
    case (i)
      2'd0:    return CH_M;
      2'd1:    return CH_P;
      2'd2:    return CH_T;
      default: return CH_X;
    endcase
  endfunction

  function automatic status_e seq_code(input logic [2:0] e);
    case (e)
      3'd1:    return ST_E_ERASE;
      3'd2:    return ST_E_VOLT;
      3'd3:    return ST_E_PROT;
      3'd4:    return ST_E_PROG;
      default: return ST_E_VMIS;
    endcase
  endfunction

  assign byte_ready_o = (ph_q != P_SEQ) && (ph_q != P_ERR);
  assign take         = byte_valid_i && byte_ready_o;
  assign asm_take     = take && (ph_q == P_OFF || ph_q == P_DATA || ph_q == P_CSUM);

  dl_word_asm i_asm (
    .clk_i, .rst_ni,
    .clr_i  (ph_q == P_HDR),
    .take_i (asm_take),
    .byte_i (byte_i),
    .done_o (asm_done),
    .word_o (asm_word)
  );

  // count byte is checked in the cycle it arrives, against the held offset
  dl_range_chk #(.BLK_BYTES_LOG2(BLK_BYTES_LOG2), .FLASH_BLOCKS(FLASH_BLOCKS)) i_rng (
    .offset_i  ((ph_q == P_OFF) ? asm_word : off_q),
    .count_i   (byte_i),
    .off_bad_o (off_bad),
    .cnt_bad_o (cnt_bad)
  );

  dl_debounce #(.DEB_CYCLES(DEB_CYCLES)) i_deb (
    .clk_i, .rst_ni, .btn_i, .press_o(press)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= P_HDR; st_q <= ST_WAIT; hdr_idx_q <= '0; prog_q <= 1'b0;
      cmd_q <= 1'b0; off_q <= '0; addr_q <= '0; csum_q <= '0;
      left_q <= '0; widx_q <= '0;
    end else begin
      cmd_q <= 1'b0;
      case (ph_q)
        P_HDR: if (take) begin
          if (byte_i == hdr_char(hdr_idx_q)) begin
            hdr_idx_q <= hdr_idx_q + 1'b1;
            if (hdr_idx_q == 2'd3) ph_q <= P_OP;
          end else begin
            hdr_idx_q <= '0;
          end
        end
        P_OP: if (take) begin
          if (byte_i == CH_P) begin
            prog_q <= 1'b1; st_q <= ST_BEGIN_PRG; ph_q <= P_OFF;
          end else if (byte_i == CH_V) begin
            prog_q <= 1'b0; st_q <= ST_BEGIN_VFY; ph_q <= P_OFF;
          end else begin
            ph_q <= P_HDR;
          end
        end
        P_OFF: if (asm_done) begin
          off_q <= asm_word;
          if (off_bad) begin
            st_q <= ST_E_OFFSET; ph_q <= P_ERR;
          end else begin
            ph_q <= P_CNT;
          end
        end
        P_CNT: if (take) begin
          if (cnt_bad) begin
            st_q <= ST_E_COUNT; ph_q <= P_ERR;
          end else begin
            left_q <= byte_i; addr_q <= off_q; csum_q <= '0; widx_q <= '0;
            st_q <= ST_READ; ph_q <= P_DATA;
          end
        end
        P_DATA: if (asm_done) begin
          csum_q <= csum_q + asm_word;
          widx_q <= widx_q + 1'b1;
          if (widx_q == '1) ph_q <= P_CSUM;
        end
        P_CSUM: if (asm_done) begin
          if (asm_word == csum_q) begin
            cmd_q <= 1'b1;
            st_q  <= prog_q ? ST_WRITE : ST_VERIFY;
            ph_q  <= P_SEQ;
          end else begin
            st_q <= ST_E_CSUM; ph_q <= P_ERR;
          end
        end
        P_SEQ: begin
          if (seq_done_i) begin
            if (seq_err_i != 3'd0) begin
              st_q <= seq_code(seq_err_i); ph_q <= P_ERR;
            end else if (left_q == 8'd1) begin
              st_q <= ST_WAIT; ph_q <= P_HDR; hdr_idx_q <= '0;
            end else begin
              left_q <= left_q - 1'b1; addr_q <= addr_q + BLK_BYTES;
              csum_q <= '0; widx_q <= '0; st_q <= ST_READ; ph_q <= P_DATA;
            end
          end else if (prog_q && seq_vphase_i) begin
            st_q <= ST_VERIFY;
          end
        end
        default: if (press) begin
          st_q <= ST_WAIT; ph_q <= P_HDR; hdr_idx_q <= '0;
        end
      endcase
    end
  end

  assign word_valid_o = asm_done && (ph_q == P_DATA);
  assign word_o       = asm_word;
  assign cmd_valid_o  = cmd_q;
  assign cmd_prog_o   = prog_q;
  assign cmd_addr_o   = addr_q;
  assign status_o     = st_q;

  a_r7_cmd_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
  a_r7_cmd_after_csum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asm_done && ph_q == P_CSUM && asm_word != csum_q |=> !cmd_valid_o);
  a_r10_addr_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_addr_o[BLK_BYTES_LOG2-1:0] == '0) && (cmd_addr_o < FLASH_LIM));
  a_r6_word_only_reading: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> status_o == ST_READ);
  a_r8_no_byte_in_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !byte_ready_o);
  a_r11_err_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == P_ERR && !press) |=> (ph_q == P_ERR) && $stable(status_o));
endmodule

// File: tb/test_dl_cmd_parser.sv
module test_dl_cmd_parser;
  localparam int WL  = 3;
  localparam int BW  = 1 << WL;
  localparam int BB  = BW * 4;
  localparam int NB  = 8;
  localparam int DEB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic byte_valid = 1'b0; logic [7:0] byte_d = '0;
  logic btn = 1'b0, vph = 1'b0, done = 1'b0; logic [2:0] serr = '0;
  logic byte_ready, word_valid, cmd_valid, cmd_prog;
  logic [31:0] word, cmd_addr; logic [3:0] status;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dl_cmd_parser #(.BLK_WORDS_LOG2(WL), .FLASH_BLOCKS(NB), .DEB_CYCLES(DEB)) i_dl_cmd_parser (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(byte_valid), .byte_i(byte_d),
    .byte_ready_o(byte_ready), .btn_i(btn), .seq_vphase_i(vph), .seq_done_i(done),
    .seq_err_i(serr), .word_valid_o(word_valid), .word_o(word),
    .cmd_valid_o(cmd_valid), .cmd_prog_o(cmd_prog), .cmd_addr_o(cmd_addr), .status_o(status));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_st(input string req, input logic [3:0] exp);
    chk(status == exp, req, 32'(status), 32'(exp));
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    while (!byte_ready) @(negedge clk);
    byte_valid = 1'b1; byte_d = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w, input bit is_data);
    for (int k = 0; k < 3; k++) send_byte(w[8*k +: 8]);
    @(negedge clk);
    byte_valid = 1'b1; byte_d = w[31:24];
    #1;
    chk(word_valid == is_data, "R6 word strobe", 32'(word_valid), 32'(is_data));
    if (is_data) chk(word == w, "R6 word value", word, w);
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic send_hdr(input logic [7:0] op);
    send_byte(8'h4D); send_byte(8'h50); send_byte(8'h54); send_byte(8'h21); send_byte(op);
  endtask

  task automatic send_params(input logic [31:0] off, input logic [7:0] cnt);
    send_word(off, 1'b0);
    if (status != 4'd6) send_byte(cnt);
  endtask

  // sends one block; returns with the command cycle visible
  task automatic send_block(input logic [31:0] addr, input bit prog, input bit good);
    logic [31:0] sum = '0;
    for (int i = 0; i < BW; i++) begin
      logic [31:0] w = $urandom;
      sum += w;
      send_word(w, 1'b1);
    end
    send_word(good ? sum : sum ^ 32'h1, 1'b0);
    if (good) begin
      chk(cmd_valid == 1'b1, "R7 cmd pulse", 32'(cmd_valid), 1);
      chk(cmd_prog == prog, "R7 cmd mode", 32'(cmd_prog), 32'(prog));
      chk(cmd_addr == addr, "R7 cmd addr", cmd_addr, addr);
      chk_st("R8 busy status", prog ? 4'd4 : 4'd5);
      chk(byte_ready == 1'b0, "R8 ready low", 32'(byte_ready), 0);
      @(negedge clk);
      chk(cmd_valid == 1'b0, "R7 single pulse", 32'(cmd_valid), 0);
    end else begin
      chk_st("R7 checksum error", 4'd8);
      chk(cmd_valid == 1'b0, "R7 no cmd", 32'(cmd_valid), 0);
    end
  endtask

  task automatic finish_seq(input bit prog, input logic [2:0] e);
    if (prog) begin
      vph = 1'b1;
      @(negedge clk);
      chk_st("R8 verify phase", 4'd5);
    end
    done = 1'b1; serr = e;
    @(negedge clk);
    done = 1'b0; serr = '0; vph = 1'b0;
  endtask

  task automatic press(input int len);
    btn = 1'b1;
    repeat (len) @(negedge clk);
    btn = 1'b0;
    repeat (DEB + 6) @(negedge clk);
  endtask

  task automatic run_xfer(input bit prog, input logic [31:0] off, input int cnt);
    send_hdr(prog ? 8'h50 : 8'h56);
    chk_st("R3 begin", prog ? 4'd1 : 4'd2);
    send_params(off, 8'(cnt));
    chk_st("R5 reading", 4'd3);
    for (int b = 0; b < cnt; b++) begin
      send_block(off + 32'(b * BB), prog, 1'b1);
      finish_seq(prog, 3'd0);
      chk_st("R10 next", (b == cnt - 1) ? 4'd0 : 4'd3);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk_st("R1 reset status", 4'd0);
    chk(byte_ready == 1'b1, "R1 ready", 32'(byte_ready), 1);
    chk(cmd_valid == 1'b0 && word_valid == 1'b0, "R1 strobes", 32'(cmd_valid), 0);
    rst_n = 1'b1;

    // R2 resync: "MM" then "PT!P" must not start
    send_byte(8'h4D); send_byte(8'h4D); send_byte(8'h50);
    send_byte(8'h54); send_byte(8'h21); send_byte(8'h50);
    chk_st("R2 resync silent", 4'd0);
    send_byte(8'h4D); send_byte(8'h50); send_byte(8'h58);
    chk_st("R2 mismatch silent", 4'd0);
    send_hdr(8'h51);
    chk_st("R3 bad op", 4'd0);

    // multi-block program, R10
    run_xfer(1'b1, 32'h40, 2);
    run_xfer(1'b0, 32'h0, 1);
    run_xfer(1'b0, 32'hE0, 1);

    // R4 offset errors and R11 button
    send_hdr(8'h56); send_params(32'h21, 8'd1);
    chk_st("R4 unaligned", 4'd6);
    chk(byte_ready == 1'b0, "R11 ready low in error", 32'(byte_ready), 0);
    press(2);
    chk_st("R11 short press ignored", 4'd6);
    press(DEB + 3);
    chk_st("R11 restart", 4'd0);
    send_hdr(8'h50); send_params(32'h100, 8'd1);
    chk_st("R4 beyond flash", 4'd6);
    press(DEB + 3);
    send_hdr(8'h50); send_params(32'hFFFF_FFE0, 8'd1);
    chk_st("R4 huge offset", 4'd6);
    press(DEB + 3);

    // R5 count errors
    send_hdr(8'h56); send_params(32'h0, 8'd0);
    chk_st("R5 zero count", 4'd7);
    press(DEB + 3);
    send_hdr(8'h56); send_params(32'hE0, 8'd2);
    chk_st("R5 overrun", 4'd7);
    press(DEB + 3);
    send_hdr(8'h50); send_params(32'h0, 8'd255);
    chk_st("R5 count 255", 4'd7);
    press(DEB + 3);
    send_hdr(8'h56); send_params(32'h0, 8'd8);
    chk_st("R5 whole flash ok", 4'd3);
    send_block(32'h0, 1'b0, 1'b0);   // R7 checksum mismatch
    press(DEB + 3);
    chk_st("R11 after csum", 4'd0);

    // R9 sequencer error codes
    for (int e = 1; e <= 6; e++) begin
      send_hdr(8'h50); send_params(32'h20, 8'd1);
      send_block(32'h20, 1'b1, 1'b1);
      finish_seq(1'b1, 3'(e));
      chk_st("R9 seq error", (e >= 5) ? 4'd13 : 4'(8 + e));
      press(DEB + 3);
    end

    // random transfers
    for (int t = 0; t < 6; t++) begin
      int blk = $urandom % NB;
      int room = NB - blk;
      int cnt = 1 + ($urandom % ((room < 2) ? room : 2));
      run_xfer(1'($urandom), 32'(blk * BB), cnt);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule